// File: doc/BRIEF.md
# Privileged Status Register Guard

This block is the status word register of a simple in-order pipeline. It sits in the execute stage and accepts one request per cycle. A request is either a status write or a return-from-trap. A status write carries a new value and a per-bit write mask. The block holds the current privilege mode, which is either user or supervisor.

A write in supervisor mode updates every bit selected by the mask. A write in user mode behaves the same way as long as no privileged field would actually change. The privileged fields include the interrupt-enable bit. A user-mode write that would change a privileged field is not committed. It instead raises a synchronous, precise trap: no bit of the register changes, the faulting PC and the old mode are saved, the mode switches to supervisor, and the younger pipeline stages get a one-cycle flush along with a redirect to the fixed handler address.

A return-from-trap issued in supervisor mode restores the saved mode and redirects to the saved PC. The same return issued in user mode traps.

Top module: `psw_guard`

## Requirements
- R1: After reset the mode is supervisor (`sup_mode_o`=1), `sr_o` is all zero (interrupts disabled), `epc_o` is 0, `prev_mode_o` is user (0), and `trap_o`, `flush_o`, `redirect_o` are 0.
- R2: A valid write in supervisor mode sets `sr_o` to `(sr & ~mask) | (wdata & mask)` for every bit, privileged or not, without a trap.
- R3: A valid write in user mode that leaves every privileged bit (set in `PRIV_MASK`) unchanged is committed with the same merge rule, raises no trap and keeps the mode at user.
- R4: A user-mode write traps exactly when `((sr ^ wdata) & mask & PRIV_MASK) != 0`. Rewriting a privileged bit with its current value does not trap, and neither does a privileged bit outside the mask.
- R5: When a trap is taken, no bit of `sr_o` changes, including the non-privileged bits selected in the same write.
- R6: A trap shows in the cycle after the request: `trap_o`, `flush_o` and `redirect_o` pulse for one cycle, `redirect_pc_o` equals `TRAP_VEC`, and the mode is supervisor.
- R7: A trap stores the request's PC in `epc_o` and the mode it came from (user, 0) in `prev_mode_o`.
- R8: A valid return in supervisor mode sets the mode to `prev_mode_o` and pulses `flush_o` and `redirect_o` with `redirect_pc_o` equal to `epc_o`. It raises no trap and leaves `sr_o` unchanged.
- R9: A valid return in user mode traps with the same effects as R5 to R7.
- R10: When a return and a write are presented together, the return is acted on and the write is discarded.
- R11: A request with `valid_i` low changes no state and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Execute-stage request valid |
| pc_i | input | PC_W | PC of the request |
| sr_we_i | input | 1 | Status write request |
| sr_wdata_i | input | SR_W | Proposed status value |
| sr_wmask_i | input | SR_W | Bits the write intends to change |
| trap_ret_i | input | 1 | Return-from-trap request |
| sr_o | output | SR_W | Current status word |
| sup_mode_o | output | 1 | 1 = supervisor, 0 = user |
| prev_mode_o | output | 1 | Mode saved by the last trap |
| epc_o | output | PC_W | PC saved by the last trap |
| trap_o | output | 1 | One-cycle trap pulse |
| flush_o | output | 1 | One-cycle flush of younger stages |
| redirect_o | output | 1 | One-cycle fetch redirect |
| redirect_pc_o | output | PC_W | Redirect target |

## Verification
The bench builds the block with two privileged bits (`PRIV_MASK` = 8'hC0) and a non-default handler address of 32'h200. Having two privileged bits makes it possible to test a trap caused only by the second privileged field. It also allows mixed writes where the same-value rule, the unmasked privileged bits and the flag bits interact within a single request. The non-default handler address means a redirect to the handler cannot be mistaken for a return to a saved PC of zero.

// File: rtl/psw_guard_pkg.sv
package psw_guard_pkg;

  typedef enum logic {
    MODE_USER = 1'b0,
    MODE_SUP  = 1'b1
  } mode_e;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_WRITE = 2'd1,
    ACT_TRAP  = 2'd2,
    ACT_RET   = 2'd3
  } act_e;

endpackage

// File: rtl/psw_decide.sv
module psw_decide
  import psw_guard_pkg::*;
#(
  parameter int unsigned     SR_W      = 8,
  parameter logic [SR_W-1:0] PRIV_MASK = 'h80
) (
  input  logic            valid_i,
  input  logic            we_i,
  input  logic            ret_i,
  input  mode_e           mode_i,
  input  logic [SR_W-1:0] sr_i,
  input  logic [SR_W-1:0] wdata_i,
  input  logic [SR_W-1:0] wmask_i,
  output act_e            act_o
);

  logic [SR_W-1:0] priv_flip;
  logic            priv_hit;

  // only bits that would actually change count as a violation
  assign priv_flip = (sr_i ^ wdata_i) & wmask_i & PRIV_MASK;
  assign priv_hit  = |priv_flip;

  always_comb begin
    act_o = ACT_NONE;
    if (valid_i) begin
      if (ret_i) begin
        act_o = (mode_i == MODE_SUP) ? ACT_RET : ACT_TRAP;
      end else if (we_i) begin
        act_o = (mode_i == MODE_USER && priv_hit) ? ACT_TRAP : ACT_WRITE;
      end
    end
  end

endmodule

// File: rtl/psw_status_reg.sv
module psw_status_reg #(
  parameter int unsigned     SR_W      = 8,
  parameter logic [SR_W-1:0] RESET_VAL = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            commit_i,
  input  logic [SR_W-1:0] wdata_i,
  input  logic [SR_W-1:0] wmask_i,
  output logic [SR_W-1:0] sr_o
);

  for (genvar b = 0; b < SR_W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sr_o[b] <= RESET_VAL[b];
      end else if (commit_i && wmask_i[b]) begin
        sr_o[b] <= wdata_i[b];
      end
    end
  end

endmodule

// File: rtl/psw_mode_ctrl.sv
module psw_mode_ctrl
  import psw_guard_pkg::*;
#(
  parameter int unsigned     PC_W     = 32,
  parameter logic [PC_W-1:0] TRAP_VEC = 'h100
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  act_e            act_i,
  input  logic [PC_W-1:0] pc_i,
  output mode_e           mode_o,
  output mode_e           prev_mode_o,
  output logic [PC_W-1:0] epc_o,
  output logic            trap_o,
  output logic            flush_o,
  output logic            redirect_o,
  output logic [PC_W-1:0] redirect_pc_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o        <= MODE_SUP;
      prev_mode_o   <= MODE_USER;
      epc_o         <= '0;
      trap_o        <= 1'b0;
      flush_o       <= 1'b0;
      redirect_o    <= 1'b0;
      redirect_pc_o <= '0;
    end else begin
      trap_o     <= 1'b0;
      flush_o    <= 1'b0;
      redirect_o <= 1'b0;
      unique case (act_i)
        ACT_TRAP: begin
          prev_mode_o   <= mode_o;
          mode_o        <= MODE_SUP;
          epc_o         <= pc_i;
          trap_o        <= 1'b1;
          flush_o       <= 1'b1;
          redirect_o    <= 1'b1;
          redirect_pc_o <= TRAP_VEC;
        end
        ACT_RET: begin
          mode_o        <= prev_mode_o;
          flush_o       <= 1'b1;
          redirect_o    <= 1'b1;
          redirect_pc_o <= epc_o;
        end
        default: ;
      endcase
    end
  end

  // R6
  trap_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> !trap_o);

  // R6
  trap_sup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (mode_o == MODE_SUP && flush_o && redirect_o));

endmodule

// File: rtl/psw_guard.sv
module psw_guard
  import psw_guard_pkg::*;
#(
  parameter int unsigned     SR_W      = 8,
  parameter int unsigned     PC_W      = 32,
  parameter logic [SR_W-1:0] PRIV_MASK = 'h80,
  parameter logic [PC_W-1:0] TRAP_VEC  = 'h100
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            sr_we_i,
  input  logic [SR_W-1:0] sr_wdata_i,
  input  logic [SR_W-1:0] sr_wmask_i,
  input  logic            trap_ret_i,
  output logic [SR_W-1:0] sr_o,
  output logic            sup_mode_o,
  output logic            prev_mode_o,
  output logic [PC_W-1:0] epc_o,
  output logic            trap_o,
  output logic            flush_o,
  output logic            redirect_o,
  output logic [PC_W-1:0] redirect_pc_o
);

  localparam logic [SR_W-1:0] SR_RESET = '0;

  act_e  act;
  mode_e mode_q;
  mode_e prev_q;

  psw_decide #(
    .SR_W      (SR_W),
    .PRIV_MASK (PRIV_MASK)
  ) i_decide (
    .valid_i (valid_i),
    .we_i    (sr_we_i),
    .ret_i   (trap_ret_i),
    .mode_i  (mode_q),
    .sr_i    (sr_o),
    .wdata_i (sr_wdata_i),
    .wmask_i (sr_wmask_i),
    .act_o   (act)
  );

  psw_status_reg #(
    .SR_W      (SR_W),
    .RESET_VAL (SR_RESET)
  ) i_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (act == ACT_WRITE),
    .wdata_i  (sr_wdata_i),
    .wmask_i  (sr_wmask_i),
    .sr_o     (sr_o)
  );

  psw_mode_ctrl #(
    .PC_W     (PC_W),
    .TRAP_VEC (TRAP_VEC)
  ) i_mode (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .act_i         (act),
    .pc_i          (pc_i),
    .mode_o        (mode_q),
    .prev_mode_o   (prev_q),
    .epc_o         (epc_o),
    .trap_o        (trap_o),
    .flush_o       (flush_o),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o)
  );

  assign sup_mode_o  = (mode_q == MODE_SUP);
  assign prev_mode_o = (prev_q == MODE_SUP);

  // R5
  trap_no_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (sr_o == $past(sr_o)));

  // R4
  user_priv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sup_mode_o) |-> ((sr_o & PRIV_MASK) == ($past(sr_o) & PRIV_MASK)));

  // R7
  trap_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (epc_o == $past(pc_i) && !prev_mode_o && redirect_pc_o == TRAP_VEC));

  // R8
  ret_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && !trap_o) |-> (redirect_pc_o == $past(epc_o) && sr_o == $past(sr_o)));

endmodule

// File: tb/test_psw_guard.sv
`timescale 1ns/1ps
module test_psw_guard;

  localparam int unsigned     SR_W = 8;
  localparam int unsigned     PC_W = 32;
  localparam logic [SR_W-1:0] PRIV = 8'hC0;
  localparam logic [PC_W-1:0] VEC  = 32'h0000_0200;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            valid = 1'b0;
  logic [PC_W-1:0] pc = '0;
  logic            we = 1'b0;
  logic [SR_W-1:0] wdata = '0;
  logic [SR_W-1:0] wmask = '0;
  logic            ret = 1'b0;
  logic [SR_W-1:0] sr;
  logic            sup, prevm, trap, flush, redir;
  logic [PC_W-1:0] epc, rpc;

  always #2 clk = ~clk;

  psw_guard #(
    .SR_W (SR_W), .PC_W (PC_W), .PRIV_MASK (PRIV), .TRAP_VEC (VEC)
  ) i_psw_guard (
    .clk_i (clk), .rst_ni (rst_n), .valid_i (valid), .pc_i (pc),
    .sr_we_i (we), .sr_wdata_i (wdata), .sr_wmask_i (wmask),
    .trap_ret_i (ret), .sr_o (sr), .sup_mode_o (sup), .prev_mode_o (prevm),
    .epc_o (epc), .trap_o (trap), .flush_o (flush), .redirect_o (redir),
    .redirect_pc_o (rpc)
  );

  typedef struct {
    logic            trap, flush, redir, sup, prevm;
    logic [PC_W-1:0] rpc, epc;
    logic [SR_W-1:0] sr;
    string           tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;

  // model state, built from the requirements
  logic [SR_W-1:0] m_sr = '0;
  logic            m_sup = 1'b1;
  logic            m_prev = 1'b0;
  logic [PC_W-1:0] m_epc = '0;

  task automatic op(input logic v, input logic w, input logic r,
                    input logic [SR_W-1:0] d, input logic [SR_W-1:0] m,
                    input logic [PC_W-1:0] p, input string tag);
    exp_t e;
    logic tr;
    @(negedge clk);
    valid = v; we = w; ret = r; wdata = d; wmask = m; pc = p;
    e.trap = 0; e.flush = 0; e.redir = 0; e.rpc = '0; tr = 0;
    if (v) begin
      if (r) begin
        if (m_sup) begin
          m_sup = m_prev; e.redir = 1; e.flush = 1; e.rpc = m_epc;
        end else tr = 1;
      end else if (w) begin
        if (!m_sup && |((m_sr ^ d) & m & PRIV)) tr = 1;
        else m_sr = (m_sr & ~m) | (d & m);
      end
    end
    if (tr) begin
      m_prev = m_sup; m_sup = 1; m_epc = p;
      e.trap = 1; e.flush = 1; e.redir = 1; e.rpc = VEC;
    end
    e.sup = m_sup; e.prevm = m_prev; e.epc = m_epc; e.sr = m_sr; e.tag = tag;
    exp_q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        n_chk++;
        if (trap !== e.trap || flush !== e.flush || redir !== e.redir ||
            sup !== e.sup || prevm !== e.prevm || epc !== e.epc || sr !== e.sr ||
            (e.redir && rpc !== e.rpc)) begin
          n_fail++;
          $display("FAIL %s: got trap=%b flush=%b redir=%b rpc=%h sup=%b prev=%b epc=%h sr=%h, exp trap=%b flush=%b redir=%b rpc=%h sup=%b prev=%b epc=%h sr=%h",
                   e.tag, trap, flush, redir, rpc, sup, prevm, epc, sr,
                   e.trap, e.flush, e.redir, e.rpc, e.sup, e.prevm, e.epc, e.sr);
        end
      end
    end
  end

  initial begin : watchdog
    #40000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1;
    n_chk++;  // R1 reset state
    if (sr !== '0 || sup !== 1'b1 || prevm !== 1'b0 || epc !== '0 ||
        trap !== 1'b0 || flush !== 1'b0 || redir !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: got sr=%h sup=%b prev=%b epc=%h trap=%b flush=%b redir=%b, exp 00 1 0 0 0 0 0",
               sr, sup, prevm, epc, trap, flush, redir);
    end
    @(negedge clk) rst_n = 1'b1;
    op(1, 1, 0, 8'hFF, 8'hFF, 32'h10, "R2 sup full write");
    op(1, 1, 0, 8'h00, 8'h0F, 32'h14, "R2 sup masked write");
    op(0, 1, 0, 8'h00, 8'hFF, 32'h18, "R11 invalid write");
    op(0, 0, 1, 8'h00, 8'h00, 32'h1C, "R11 invalid return");
    op(1, 0, 1, 8'h00, 8'h00, 32'h20, "R8 return to user");
    op(1, 1, 0, 8'h05, 8'h3F, 32'h24, "R3 user flag write");
    op(1, 1, 0, 8'hC0, 8'hC0, 32'h28, "R4 user same-value priv write");
    op(1, 1, 0, 8'h0A, 8'hBF, 32'h2C, "R4 R5 R6 R7 user clears enable");
    op(1, 0, 0, 8'h00, 8'h00, 32'h30, "R6 pulse ends");
    op(1, 0, 1, 8'h00, 8'h00, 32'h34, "R8 return after trap");
    op(1, 0, 1, 8'h00, 8'h00, 32'h88, "R9 user return traps");
    op(1, 1, 1, 8'h00, 8'hFF, 32'h8C, "R10 return with write");
    op(1, 1, 0, 8'h85, 8'h40, 32'h90, "R4 second priv bit traps");
    op(1, 0, 1, 8'h00, 8'h00, 32'h94, "R8 return again");
    op(1, 1, 0, 8'h00, 8'h3F, 32'h98, "R4 unmasked priv bits no trap");
    op(1, 1, 0, 8'h3F, 8'h3F, 32'h9C, "R3 user sets all flags");
    op(0, 0, 0, 8'h00, 8'h00, 32'h00, "R11 idle");
    repeat (4) @(posedge clk);
    #1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule